// File: doc/BRIEF.md
# Automatic Bus Polarity Reversal Controller

This block chooses whether the two pins of a half-duplex differential bus are used swapped or not. It sits between a node's logic and its line interface. The transmit bit is steered onto the pin pair, and a signed sample of the line difference is decoded into a receive bit. One polarity flag controls both directions.

When the node is only listening and the decoded receive bit stays low for a long qualifying window, the controller concludes that the cable pair is crossed and toggles the polarity flag. Real traffic never holds the line low for that long. An idle, open or terminated bus reads as a zero difference, and the decode keeps that value high in both polarity states. If the swap was a wrong guess, another full window of stuck-low toggles the flag back.

The window length `WAIT_CYC` is given in clock cycles. At the default of 10,000,000 cycles it is 200 ms at 50 MHz. The decoded bit passes through a two-stage synchroniser before it is counted or presented.

Top module: `bus_polarity_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it rises, `pol_rev` is 0 (normal polarity), `rx_data` is 1 and the low-run count is zero.
- R2: With `pol_rev` = 0, `tx_p` equals `tx_data` and `tx_n` equals its inverse. With `pol_rev` = 1 the two pins are swapped: `tx_p` = ~`tx_data` and `tx_n` = `tx_data`.
- R3: The decoded bit is 1 when `line_diff` >= 0 in normal polarity, and 1 when `line_diff` <= 0 in reversed polarity; otherwise it is 0. `rx_data` shows the decoded bit two clock edges after the sample.
- R4: A `line_diff` of zero (idle bus) gives `rx_data` = 1 in both polarity states and never leads to a reversal.
- R5: Listening means `drv_en` = 0 and `rcv_en_n` = 0. If the synchronised receive bit is 0 on `WAIT_CYC` consecutive listening clock edges, `pol_rev` toggles on the last of those edges.
- R6: A synchronised receive bit of 1 clears the low-run count, so a single high sample restarts the full window.
- R7: An edge on which the node is not listening (`drv_en` = 1 or `rcv_en_n` = 1) clears the low-run count, and `pol_rev` never changes on such an edge.
- R8: After each toggle the count restarts from zero. A further full window of stuck-low while listening toggles `pol_rev` back.
- R9: Transmit and receive always follow the same `pol_rev` value and are never reversed separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | 1 | Driver enable, high while the node transmits |
| rcv_en_n | input | 1 | Receiver enable, active low |
| line_diff | input | DIFF_W (signed) | Sampled line difference, pin 1 minus pin 2 |
| tx_data | input | 1 | Bit to transmit |
| pol_rev | output | 1 | 1 when the bus pins are treated as swapped |
| rx_data | output | 1 | Polarity-corrected, synchronised receive bit |
| tx_p | output | 1 | Level for bus pin 1 |
| tx_n | output | 1 | Level for bus pin 2 |

## Verification
A wrong polarity flag shows on the ports at once. The transmit pins flip on the same edge. The receive bit shows the wrong value two edges later, unless the line is idle, because an idle line decodes high either way. A low-run count that is wrong, or that is not cleared, shows only as a toggle of `pol_rev` on the wrong edge. That can be up to a full window after the fault. A reference model therefore predicts the exact edge of every toggle and compares all outputs on every clock, so a toggle one edge early or late is reported.

// File: rtl/bus_polarity_ctrl.sv
module bus_polarity_ctrl #(
  parameter int WAIT_CYC = 10_000_000,
  parameter int DIFF_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     drv_en,
  input  logic                     rcv_en_n,
  input  logic signed [DIFF_W-1:0] line_diff,
  input  logic                     tx_data,
  output logic                     pol_rev,
  output logic                     rx_data,
  output logic                     tx_p,
  output logic                     tx_n
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

  logic             swap_q;
  logic             sync1_q, sync2_q;
  logic [CNT_W-1:0] run_q;
  logic             listen, dec_bit;

  assign listen  = !drv_en && !rcv_en_n;
  assign dec_bit = swap_q ? (line_diff <= 0) : (line_diff >= 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      run_q   <= '0;
      swap_q  <= 1'b0;
    end else begin
      sync1_q <= dec_bit;
      sync2_q <= sync1_q;
      if (listen && !sync2_q) begin
        if (run_q == LAST) begin
          run_q  <= '0;
          swap_q <= ~swap_q;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign pol_rev = swap_q;
  assign rx_data = sync2_q;
  assign tx_p    = swap_q ? ~tx_data : tx_data;
  assign tx_n    = ~tx_p;

  // R7
  flip_only_listening_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_rev != $past(pol_rev)) |-> $past(listen));

  // R5
  flip_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_rev != $past(pol_rev)) |-> ($past(run_q) == LAST && !$past(rx_data)));

  // R6
  high_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_data |=> (run_q == '0));

  // R7
  idle_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !listen |=> (run_q == '0));

  // R8
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_rev != $past(pol_rev)) |-> (run_q == '0));

  // R5
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= LAST);
endmodule

// File: tb/sim_bus_polarity_ctrl.sv
module sim_bus_polarity_ctrl;
  localparam int WAIT = 40;
  localparam int DW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drv_en = 1'b0, rcv_en_n = 1'b0, tx_data = 1'b0;
  logic signed [DW-1:0] line_diff = '0;
  logic pol_rev, rx_data, tx_p, tx_n;

  int total = 0, bad = 0, cyc = 0;

  bus_polarity_ctrl #(.WAIT_CYC(WAIT), .DIFF_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .rcv_en_n(rcv_en_n),
    .line_diff(line_diff), .tx_data(tx_data), .pol_rev(pol_rev),
    .rx_data(rx_data), .tx_p(tx_p), .tx_n(tx_n));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: polarity flag, run length, two-deep delay queue
  bit m_pol;
  int m_run;
  bit m_q[$];

  function automatic bit decode(input int d, input bit p);
    return p ? (d <= 0) : (d >= 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pol = 1'b0; m_run = 0; m_q = '{1'b1, 1'b1};
    end else begin
      bit lst, nd;
      lst = !drv_en && !rcv_en_n;
      nd  = decode(int'(line_diff), m_pol);
      if (lst && m_q[0] == 1'b0) begin
        m_run++;
        if (m_run == WAIT) begin m_pol = ~m_pol; m_run = 0; end
      end else m_run = 0;
      void'(m_q.pop_front());
      m_q.push_back(nd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    #5;
    if (rst_n) begin
      chk(pol_rev == m_pol, "R5 pol_rev vs model", pol_rev, m_pol);
      chk(rx_data == m_q[0], "R3 rx_data vs model", rx_data, m_q[0]);
      chk(tx_p == (m_pol ? ~tx_data : tx_data), "R2 tx_p", tx_p, m_pol ? ~tx_data : tx_data);
      chk(tx_n == ~tx_p, "R2 tx_n", tx_n, ~tx_p);
    end
    if (cyc == 20000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic hold(input int n, input bit de, input bit ren, input int d, input bit td);
    @(negedge clk);
    drv_en = de; rcv_en_n = ren; line_diff = DW'(d); tx_data = td;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(pol_rev == 0, "R1 pol_rev in reset", pol_rev, 0);
    chk(rx_data == 1, "R1 rx_data in reset", rx_data, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pol_rev == 0, "R1 pol_rev after reset", pol_rev, 0);
    // R2 normal mapping while driving
    hold(3, 1, 1, 50, 1);
    chk(tx_p == 1 && tx_n == 0, "R2 normal tx 1", tx_p, 1);
    hold(3, 1, 1, 50, 0);
    chk(tx_p == 0 && tx_n == 1, "R2 normal tx 0", tx_p, 0);
    // R3 positive decodes high in normal
    hold(5, 0, 0, 30, 0);
    chk(rx_data == 1, "R3 positive normal", rx_data, 1);
    hold(5, 0, 0, -30, 0);
    chk(rx_data == 0, "R3 negative normal", rx_data, 0);
    // R4 idle zero, long
    hold(100, 0, 0, 0, 0);
    chk(rx_data == 1, "R4 zero normal", rx_data, 1);
    chk(pol_rev == 0, "R4 no flip idle", pol_rev, 0);
    // R6 high pulse restarts window
    hold(30, 0, 0, -20, 0);
    hold(1, 0, 0, 20, 0);
    hold(30, 0, 0, -20, 0);
    chk(pol_rev == 0, "R6 pulse restarts", pol_rev, 0);
    // R7 leaving listen clears and blocks
    hold(5, 0, 0, 20, 0);
    hold(30, 0, 0, -20, 0);
    hold(5, 1, 0, -20, 0);
    hold(30, 0, 0, -20, 0);
    chk(pol_rev == 0, "R7 driver enable clears", pol_rev, 0);
    hold(5, 0, 1, -20, 0);
    hold(60, 0, 1, -20, 0);
    chk(pol_rev == 0, "R7 receiver disabled blocks", pol_rev, 0);
    // R5 stuck low while listening flips
    hold(45, 0, 0, -20, 0);
    chk(pol_rev == 1, "R5 flip after window", pol_rev, 1);
    chk(rx_data == 1, "R9 negative reads high reversed", rx_data, 1);
    // R9 tx follows same flag
    hold(2, 1, 1, 0, 1);
    chk(tx_p == 0 && tx_n == 1, "R9 reversed tx 1", tx_p, 0);
    // R4 zero in reversed
    hold(60, 0, 0, 0, 0);
    chk(rx_data == 1, "R4 zero reversed", rx_data, 1);
    chk(pol_rev == 1, "R4 no flip idle reversed", pol_rev, 1);
    // R8 positive stuck reads low, flips back
    hold(20, 0, 0, 25, 0);
    chk(rx_data == 0, "R3 positive reversed", rx_data, 0);
    chk(pol_rev == 1, "R8 still reversed mid window", pol_rev, 1);
    hold(30, 0, 0, 25, 0);
    chk(pol_rev == 0, "R8 flipped back", pol_rev, 0);
    chk(rx_data == 1, "R8 positive normal again", rx_data, 1);
    hold(5, 0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule